// File: doc/BRIEF.md
# Two-Tier Shared Bus Arbiter

This block decides which bus master owns a shared PCI-style bus. Several external masters and one host CPU compete for it. Each external master has a request line and a grant line. A configuration bit places each external master in either the high queue or the low queue. Between two low-queue grants, every requesting high-queue master gets one turn. The CPU is slotted in after a programmable number of finished external tenures, from 1 to 3. When nobody asks for the bus, the grant rests on the CPU.

Ownership moves only on a cycle where the bus is idle. At that point the current owner must either have withdrawn its request, or have its latency-timer expiry asserted while another request is waiting. A second mode serialises external masters behind the host bus: an external master is told it owns the PCI bus only in cycles where the host-bus grant handshake is also present. All grant outputs are registered and change on the clock edge after the deciding cycle.

Top module: `pci_tier_arbiter`

## Requirements
- R1: During and directly after synchronous reset `rst`, `ext_gnt` is all zero, `cpu_gnt` is 1 and `host_req` is 0. The share counter is zero, and both rotation pointers sit so that index 0 is the first candidate in each queue.
- R2: At a hand-over, a requesting high-queue master (bit set in `ext_hiq`) that has not yet been served since the last low-queue grant is chosen before any low-queue master. A low-queue grant clears the served set.
- R3: The low queue rotates round-robin. The next candidate is the first requesting low-queue index after the last low-queue grantee, wrapping. Non-requesters are skipped and lose their turn.
- R4: Each hand-over away from an external owner adds one to a counter that saturates at 3. At a hand-over, if `cpu_req` is 1 and the counter (this hand-over included) is at least the share setting, the CPU wins and the counter returns to 0. The share setting is `cpu_share`, with code 0 treated as 1. A non-requesting CPU is skipped and the counter keeps its value.
- R5: A hand-over happens only in a cycle with `bus_idle`=1 and either the owner's request low, or the owner's expiry (`ext_tmo` bit or `cpu_tmo`) high while some other request is pending. The new grant appears one edge later.
- R6: At a hand-over with no external request and no CPU request, the grant rests on the CPU.
- R7: When `lock_host`=1 and an external master is the owner, `host_req` is 1. That master's `ext_gnt` bit is 1 only in cycles following a sampled `host_gnt`=1.
- R8: At most one of `ext_gnt` bits and `cpu_gnt` is high at any time.
- R9: The high queue rotates round-robin in the same way as the low queue, so two high-queue masters alternate. When all requesting high-queue masters have been served and no low-queue master asks, the served set restarts from the newly chosen high-queue master.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | N_EXT | Request from each external master |
| ext_hiq | input | N_EXT | Queue select per master, 1 = high queue |
| ext_tmo | input | N_EXT | Latency-timer expiry per external master |
| cpu_req | input | 1 | CPU request |
| cpu_tmo | input | 1 | CPU tenure expiry |
| cpu_share | input | 2 | External hand-overs per CPU slot (0 acts as 1) |
| bus_idle | input | 1 | Bus is between transactions |
| lock_host | input | 1 | Nonconcurrent mode enable |
| host_gnt | input | 1 | Host-bus grant handshake |
| ext_gnt | output | N_EXT | Grant to each external master |
| cpu_gnt | output | 1 | Grant to the CPU |
| host_req | output | 1 | Request for the host bus in nonconcurrent mode |

## Verification
A corrupt rotation pointer or served set shows up at the next hand-over as a grant to the wrong index. A stuck share counter shows up as a CPU grant that comes a tenure early or late. Because every grant is registered straight from the owner state, any such fault reaches the ports exactly one edge after the idle cycle that decided it. The bench sweeps every queue assignment, share code and mode over a long pseudo-random traffic stream. It compares all outputs each cycle against an arithmetic model.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;
  typedef enum logic [2:0] {
    PICK_HOLD,
    PICK_CPU_SHARE,
    PICK_HIGH,
    PICK_LOW,
    PICK_HIGH_RESTART,
    PICK_CPU_PLAIN,
    PICK_PARK
  } pick_t;

  function automatic logic [1:0] share_eff(input logic [1:0] code);
    return (code == 2'd0) ? 2'd1 : code;
  endfunction
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last) + k) % N;
      if (!found && mask[j]) begin
        found = 1'b1;
        idx   = j[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/share_counter.sv
module share_counter (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  input  logic       clr,
  input  logic [1:0] share,
  output logic       due
);
  import pci_arb_pkg::*;
  logic [1:0] cnt_q;
  logic [1:0] cnt_inc;

  assign cnt_inc = (inc && cnt_q != 2'd3) ? cnt_q + 2'd1 : cnt_q;
  assign due     = cnt_inc >= share_eff(share);

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= 2'd0;
    else if (clr) cnt_q <= 2'd0;
    else          cnt_q <= cnt_inc;
  end

  assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt_q == 2'd0);
  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/grant_stage.sv
module grant_stage #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          own_cpu_n,
  input  logic [IW-1:0] own_idx_n,
  input  logic          lock_host,
  input  logic          host_gnt,
  output logic [N-1:0]  ext_gnt,
  output logic          cpu_gnt,
  output logic          host_req
);
  logic ext_ok;
  assign ext_ok = !own_cpu_n && (!lock_host || host_gnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_gnt  <= '0;
      cpu_gnt  <= 1'b1;
      host_req <= 1'b0;
    end else begin
      ext_gnt  <= ext_ok ? (N'(1) << own_idx_n) : '0;
      cpu_gnt  <= own_cpu_n;
      host_req <= lock_host && !own_cpu_n;
    end
  end

  assert_one_owner_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ext_gnt, cpu_gnt}));
  assert_host_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (lock_host && host_gnt == 1'b0 && !own_cpu_n) |=> ext_gnt == '0);
endmodule

// File: rtl/pci_tier_arbiter.sv
module pci_tier_arbiter #(
  parameter int N_EXT = 4,
  localparam int IW   = (N_EXT > 1) ? $clog2(N_EXT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] ext_req,
  input  logic [N_EXT-1:0] ext_hiq,
  input  logic [N_EXT-1:0] ext_tmo,
  input  logic             cpu_req,
  input  logic             cpu_tmo,
  input  logic [1:0]       cpu_share,
  input  logic             bus_idle,
  input  logic             lock_host,
  input  logic             host_gnt,
  output logic [N_EXT-1:0] ext_gnt,
  output logic             cpu_gnt,
  output logic             host_req
);
  import pci_arb_pkg::*;

  localparam int NPICK = 3;
  localparam logic [IW-1:0] LAST_IDX = IW'(N_EXT - 1);

  logic             own_cpu_q, own_cpu_n;
  logic [IW-1:0]    own_idx_q, own_idx_n;
  logic [N_EXT-1:0] served_q, served_n;
  logic [IW-1:0]    hi_last_q, hi_last_n, lo_last_q, lo_last_n;
  logic             cnt_clr, share_due;
  pick_t            pick;

  logic [N_EXT-1:0] own_oh, others;
  logic             own_req, own_tmo, any_other, tenure_end, ext_done;

  logic [N_EXT-1:0] pmask [NPICK];
  logic [IW-1:0]    plast [NPICK];
  logic             pfound[NPICK];
  logic [IW-1:0]    pidx  [NPICK];

  assign own_oh     = own_cpu_q ? '0 : (N_EXT'(1) << own_idx_q);
  assign own_req    = own_cpu_q ? cpu_req : ext_req[own_idx_q];
  assign own_tmo    = own_cpu_q ? cpu_tmo : ext_tmo[own_idx_q];
  assign others     = ext_req & ~own_oh;
  assign any_other  = (|others) || (cpu_req && !own_cpu_q);
  assign tenure_end = bus_idle && (!own_req || (own_tmo && any_other));
  assign ext_done   = tenure_end && !own_cpu_q;

  // picker 0: unserved high, 1: any high, 2: low
  assign pmask[0] = ext_req & ext_hiq & ~served_q;
  assign pmask[1] = ext_req & ext_hiq;
  assign pmask[2] = ext_req & ~ext_hiq;
  assign plast[0] = hi_last_q;
  assign plast[1] = hi_last_q;
  assign plast[2] = lo_last_q;

  for (genvar g = 0; g < NPICK; g++) begin : g_pick
    rr_picker #(.N(N_EXT), .IW(IW)) u_pick (
      .mask (pmask[g]),
      .last (plast[g]),
      .found(pfound[g]),
      .idx  (pidx[g])
    );
  end

  share_counter u_share (
    .clk  (clk),
    .rst  (rst),
    .inc  (ext_done),
    .clr  (cnt_clr),
    .share(cpu_share),
    .due  (share_due)
  );

  always_comb begin
    own_cpu_n = own_cpu_q;
    own_idx_n = own_idx_q;
    served_n  = served_q;
    hi_last_n = hi_last_q;
    lo_last_n = lo_last_q;
    cnt_clr   = 1'b0;
    pick      = PICK_HOLD;
    if (tenure_end) begin
      if (cpu_req && share_due) begin
        pick      = PICK_CPU_SHARE;
        own_cpu_n = 1'b1;
        cnt_clr   = 1'b1;
      end else if (pfound[0]) begin
        pick      = PICK_HIGH;
        own_cpu_n = 1'b0;
        own_idx_n = pidx[0];
        hi_last_n = pidx[0];
        served_n  = served_q | (N_EXT'(1) << pidx[0]);
      end else if (pfound[2]) begin
        pick      = PICK_LOW;
        own_cpu_n = 1'b0;
        own_idx_n = pidx[2];
        lo_last_n = pidx[2];
        served_n  = '0;
      end else if (pfound[1]) begin
        pick      = PICK_HIGH_RESTART;
        own_cpu_n = 1'b0;
        own_idx_n = pidx[1];
        hi_last_n = pidx[1];
        served_n  = N_EXT'(1) << pidx[1];
      end else if (cpu_req) begin
        pick      = PICK_CPU_PLAIN;
        own_cpu_n = 1'b1;
        cnt_clr   = 1'b1;
      end else begin
        pick      = PICK_PARK;
        own_cpu_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_cpu_q <= 1'b1;
      own_idx_q <= '0;
      served_q  <= '0;
      hi_last_q <= LAST_IDX;
      lo_last_q <= LAST_IDX;
    end else begin
      own_cpu_q <= own_cpu_n;
      own_idx_q <= own_idx_n;
      served_q  <= served_n;
      hi_last_q <= hi_last_n;
      lo_last_q <= lo_last_n;
    end
  end

  grant_stage #(.N(N_EXT), .IW(IW)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .own_cpu_n(own_cpu_n),
    .own_idx_n(own_idx_n),
    .lock_host(lock_host),
    .host_gnt (host_gnt),
    .ext_gnt  (ext_gnt),
    .cpu_gnt  (cpu_gnt),
    .host_req (host_req)
  );

  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_idle |=> $stable(own_cpu_q) && $stable(own_idx_q));
  assert_rest_cpu_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_idle && ext_req == '0 && !cpu_req) |=> cpu_gnt);
  assert_low_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (pick == PICK_LOW) |=> served_q == '0);
  assert_low_is_low_R3: assert property (@(posedge clk) disable iff (rst)
    (pick == PICK_LOW) |=> !own_cpu_q && !ext_hiq[own_idx_q] || $changed(ext_hiq));
  assert_host_req_R7: assert property (@(posedge clk) disable iff (rst)
    (lock_host && !own_cpu_n) |=> host_req);
endmodule

// File: tb/tb_pci_tier_arbiter.sv
module tb_pci_tier_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] ext_req = '0, ext_hiq = '0, ext_tmo = '0;
  logic         cpu_req = 1'b0, cpu_tmo = 1'b0, bus_idle = 1'b0;
  logic         lock_host = 1'b0, host_gnt = 1'b0;
  logic [1:0]   cpu_share = 2'd1;
  logic [N-1:0] ext_gnt;
  logic         cpu_gnt, host_req;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // model state
  int m_cpu, m_idx, m_hlast, m_llast, m_cnt;
  int m_served;
  string m_tag;

  always #2.5 clk = ~clk;

  pci_tier_arbiter #(.N_EXT(N)) dut (
    .clk(clk), .rst(rst), .ext_req(ext_req), .ext_hiq(ext_hiq),
    .ext_tmo(ext_tmo), .cpu_req(cpu_req), .cpu_tmo(cpu_tmo),
    .cpu_share(cpu_share), .bus_idle(bus_idle), .lock_host(lock_host),
    .host_gnt(host_gnt), .ext_gnt(ext_gnt), .cpu_gnt(cpu_gnt),
    .host_req(host_req)
  );

  function automatic int rr(input int mask, input int last);
    for (int k = 1; k <= N; k++) begin
      int j = (last + k) % N;
      if ((mask >> j) & 1) return j;
    end
    return -1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance model by one edge using the inputs now applied
  task automatic model_step();
    int req, hi, own_req, own_tmo, others, cnt_n, share, p;
    req = int'(ext_req); hi = int'(ext_hiq);
    own_req = m_cpu ? int'(cpu_req) : ((req >> m_idx) & 1);
    own_tmo = m_cpu ? int'(cpu_tmo) : int'(ext_tmo[m_idx]);
    others  = ((m_cpu ? req : (req & ~(1 << m_idx))) != 0) || (cpu_req && !m_cpu);
    m_tag = "R5";
    if (!(bus_idle && (!own_req || (own_tmo && others)))) return;
    cnt_n = m_cnt;
    if (!m_cpu && cnt_n < 3) cnt_n++;
    share = (cpu_share == 0) ? 1 : int'(cpu_share);
    m_cnt = cnt_n;
    if (cpu_req && cnt_n >= share) begin
      m_cpu = 1; m_cnt = 0; m_tag = "R4"; return;
    end
    p = rr(req & hi & ~m_served, m_hlast);
    if (p >= 0) begin
      m_cpu = 0; m_idx = p; m_hlast = p; m_served |= (1 << p); m_tag = "R2"; return;
    end
    p = rr(req & ~hi, m_llast);
    if (p >= 0) begin
      m_cpu = 0; m_idx = p; m_llast = p; m_served = 0; m_tag = "R3"; return;
    end
    p = rr(req & hi, m_hlast);
    if (p >= 0) begin
      m_cpu = 0; m_idx = p; m_hlast = p; m_served = 1 << p; m_tag = "R9"; return;
    end
    m_cpu = 1;
    if (cpu_req) begin m_cnt = 0; m_tag = "R4"; end
    else m_tag = "R6";
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int exp_ext, hg_prev, lk_prev;
    string t;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ext_gnt", int'(ext_gnt), 0);
    check("R1 cpu_gnt", int'(cpu_gnt), 1);
    check("R1 host_req", int'(host_req), 0);
    m_cpu = 1; m_idx = 0; m_hlast = N - 1; m_llast = N - 1; m_cnt = 0; m_served = 0;
    rst = 1'b0;
    // all request, all low, idle, owner CPU not requesting -> index 0 first (R1, R3)
    ext_req = '1; bus_idle = 1'b1;
    model_step();
    @(negedge clk);
    check("R1 first pick", int'(ext_gnt), 1);
    check("R3 first pick", int'(cpu_gnt), 0);
    ext_req = '0;
    model_step();
    @(negedge clk);
    check("R6 park", int'(cpu_gnt), 1);
    for (int cfg = 0; cfg < 128; cfg++) begin
      ext_hiq   = cfg[3:0];
      cpu_share = cfg[5:4];
      lock_host = cfg[6];
      for (int cyc = 0; cyc < 150; cyc++) begin
        for (int b = 0; b < N; b++) if ($urandom % 6 == 0) ext_req[b] = ~ext_req[b];
        if ($urandom % 6 == 0) cpu_req = ~cpu_req;
        for (int b = 0; b < N; b++) ext_tmo[b] = ($urandom % 4 == 0);
        cpu_tmo  = ($urandom % 4 == 0);
        bus_idle = ($urandom % 3 != 0);
        host_gnt = ($urandom % 3 != 0);
        hg_prev = int'(host_gnt); lk_prev = int'(lock_host);
        model_step();
        t = m_tag;
        @(negedge clk);
        exp_ext = (!m_cpu && (!lk_prev || hg_prev)) ? (1 << m_idx) : 0;
        if (!m_cpu && lk_prev) t = "R7";
        check({t, " ext_gnt"}, int'(ext_gnt), exp_ext);
        check({t, " cpu_gnt"}, int'(cpu_gnt), m_cpu);
        check("R7 host_req", int'(host_req), (lk_prev && !m_cpu) ? 1 : 0);
        check("R8 single grant", $countones({ext_gnt, cpu_gnt}) <= 1, 1);
      end
    end
    finish_run();
  end
endmodule